// File: doc/BRIEF.md
# Program-ROM Instruction Sequencer

This block steps through a short program held in an internal read-only array. It turns each 8-bit instruction into the control signals of a small 4-bit register and ALU datapath. A program counter selects the current word. The word is split into a destination register address, a load-source select, an add/subtract select and a 4-bit constant. These outputs are combinational in the current counter value, so the datapath acts on them at the next rising clock edge.

On that same edge the counter moves to its next value. It either steps by one or jumps to the 3-bit constant held in the instruction. A jump may be unconditional, or it may depend on the carry flag that the datapath feeds back. The program is passed in as a packed parameter, with entry i in bits [8i+7:8i]. This lets the same block run different programs without any change to the logic.

Top module: `insn_sequencer`

## Requirements
- R1: While the synchronous, active-high reset is sampled high at a rising edge, the counter becomes 0. The instruction at address 0 is executed on the first edge after reset is released.
- R2: The instruction bits, from bit 7 down to bit 0, are: jump J (bit 7), carry-condition C (bit 6), destination address (bits 5:4), load select (bit 3), S (bit 2) and the low immediate bits (bits 1:0). The outputs reg_addr_o, load_sel_o and alu_sel_o carry bits 5:4, bit 3 and bit 2 of the word at the current counter value.
- R3: custom_o is {0, bit 2, bits 1:0}. Its top bit is always 0, so every constant lies in 0 to 7.
- R4: When no jump is taken, the counter advances by one per edge and wraps from 7 to 0.
- R5: An instruction with address 11 and J=1 loads the counter with {bit 2, bits 1:0} at the end of that instruction.
- R6: An instruction with address 11, J=0 and C=1 jumps to {bit 2, bits 1:0} only when carry_i is 1 at that edge. Otherwise the counter advances by one.
- R7: An instruction with address 11 and both J and C set is an unconditional jump, whatever the value of carry_i.
- R8: When the address field is not 11, the J, C and carry_i values have no effect, and the counter advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| carry_i | input | 1 | Carry flag from the datapath |
| reg_addr_o | output | 2 | Destination register address (11 = no write) |
| load_sel_o | output | 1 | 1 selects the constant, 0 selects the ALU result |
| alu_sel_o | output | 1 | 0 selects add, 1 selects subtract |
| custom_o | output | 4 | Constant value, top bit always 0 |
| pc_o | output | 3 | Current program counter |

## Verification
On every cycle the assertions check the counter update rules. A reset leads to 0. A non-jump word, or a conditional jump with a clear carry, leads to the next address. An unconditional jump lands on the constant that was shown in the previous cycle. The two jump kinds never decode together. The bench scenarios show what the assertions cannot. These are the full mapping from stored words to the output fields, and the path taken through a real program with carry both set and clear. They also cover the wrap from 7 to 0, the handling of J and C on words that write a register, and a reset in the middle of a run.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int INSN_W = 8;
    localparam int IMM_W  = 3;
    localparam logic [1:0] ADDR_NONE = 2'b11;

    // Field order matters: J is bit 7 down to the low immediate bits.
    typedef struct packed {
        logic       j;
        logic       c;
        logic [1:0] addr;
        logic       sreg;
        logic       s;
        logic [1:0] imm_lo;
    } insn_t;

endpackage

// File: rtl/seq_rom.sv
module seq_rom #(
    parameter int PC_W  = 3,
    parameter int WORD_W = 8,
    parameter logic [WORD_W*(2**PC_W)-1:0] IMAGE = '0
) (
    input  logic [PC_W-1:0]   addr_i,
    output logic [WORD_W-1:0] data_o
);
    localparam int DEPTH = 2 ** PC_W;

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        assign words[gi] = IMAGE[gi*WORD_W +: WORD_W];
    end

    assign data_o = words[addr_i];
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [INSN_W-1:0] raw_i,
    input  logic              carry_i,
    output logic [1:0]        reg_addr_o,
    output logic              load_sel_o,
    output logic              alu_sel_o,
    output logic [3:0]        custom_o,
    output logic [IMM_W-1:0]  target_o,
    output logic              is_uncond_o,
    output logic              is_cond_o,
    output logic              take_jump_o
);
    insn_t insn;

    always_comb begin
        insn        = insn_t'(raw_i);
        reg_addr_o  = insn.addr;
        load_sel_o  = insn.sreg;
        alu_sel_o   = insn.s;
        target_o    = {insn.s, insn.imm_lo};
        custom_o    = {1'b0, insn.s, insn.imm_lo};
        is_uncond_o = (insn.addr == ADDR_NONE) && insn.j;
        is_cond_o   = (insn.addr == ADDR_NONE) && !insn.j && insn.c;
        take_jump_o = is_uncond_o || (is_cond_o && carry_i);
    end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
    parameter int PC_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_jump_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] pc_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (take_jump_i) begin
            st_d.pc = target_i;
        end else begin
            st_d.pc = st_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    // R1: reset drives the counter to zero
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc_o == '0);

    // R4: without a jump the counter steps by one
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        !take_jump_i |=> pc_o == $past(pc_o) + PC_W'(1));

    // R5: a taken jump lands on the offered target
    a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
        take_jump_i |=> pc_o == $past(target_i));
endmodule

// File: rtl/insn_sequencer.sv
module insn_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W = 3,
    parameter logic [INSN_W*(2**PC_W)-1:0] PROG =
        {8'hF1, 8'h14, 8'hB2, 8'h20, 8'h76, 8'h00, 8'h1B, 8'h0A}
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            carry_i,
    output logic [1:0]      reg_addr_o,
    output logic            load_sel_o,
    output logic            alu_sel_o,
    output logic [3:0]      custom_o,
    output logic [PC_W-1:0] pc_o
);
    logic [INSN_W-1:0] word;
    logic [IMM_W-1:0]  target;
    logic              is_uncond, is_cond, take_jump;

    seq_rom #(.PC_W(PC_W), .WORD_W(INSN_W), .IMAGE(PROG)) u_rom (
        .addr_i (pc_o),
        .data_o (word)
    );

    seq_decode u_dec (
        .raw_i       (word),
        .carry_i     (carry_i),
        .reg_addr_o  (reg_addr_o),
        .load_sel_o  (load_sel_o),
        .alu_sel_o   (alu_sel_o),
        .custom_o    (custom_o),
        .target_o    (target),
        .is_uncond_o (is_uncond),
        .is_cond_o   (is_cond),
        .take_jump_o (take_jump)
    );

    seq_pc #(.PC_W(PC_W)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .take_jump_i (take_jump),
        .target_i    (PC_W'(target)),
        .pc_o        (pc_o)
    );

    // R2: a word cannot be both jump kinds
    a_r2_kind_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({is_cond, is_uncond}));

    // R5 and R7: unconditional jump reaches the constant shown on the port
    a_r5_uncond_port: assert property (@(posedge clk) disable iff (rst)
        is_uncond |=> pc_o == PC_W'($past(custom_o[IMM_W-1:0])));

    // R6: conditional jump with clear carry falls through
    a_r6_no_carry_step: assert property (@(posedge clk) disable iff (rst)
        (is_cond && !carry_i) |=> pc_o == $past(pc_o) + PC_W'(1));

    // R8: register-writing words never redirect the counter
    a_r8_write_no_jump: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_o != ADDR_NONE) |=> pc_o == $past(pc_o) + PC_W'(1));
endmodule

// File: tb/test_insn_sequencer.sv
`timescale 1ns/1ps
module test_insn_sequencer;

    localparam logic [63:0] PROG_MAIN =
        {8'hF1, 8'h14, 8'hB2, 8'h20, 8'h76, 8'h00, 8'h1B, 8'h0A};
    // J or C set on register-writing words, no word uses address 11
    localparam logic [63:0] PROG_WRAP =
        {8'h8D, 8'h20, 8'h14, 8'h10, 8'h04, 8'h00, 8'h5B, 8'h8D};

    // each row: {carry, expected pc}
    localparam logic [3:0] VEC [16] = '{
        {1'b0, 3'd0}, {1'b1, 3'd1}, {1'b0, 3'd2}, {1'b0, 3'd3},
        {1'b0, 3'd4}, {1'b1, 3'd5}, {1'b0, 3'd2}, {1'b1, 3'd3},
        {1'b1, 3'd6}, {1'b0, 3'd7}, {1'b0, 3'd1}, {1'b1, 3'd2},
        {1'b1, 3'd3}, {1'b0, 3'd6}, {1'b1, 3'd7}, {1'b0, 3'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst2 = 1'b1;
    logic carry = 1'b0;
    logic carry2 = 1'b1;
    logic [1:0] reg_addr, reg_addr2;
    logic load_sel, load_sel2, alu_sel, alu_sel2;
    logic [3:0] custom, custom2;
    logic [2:0] pc, pc2;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    insn_sequencer #(.PC_W(3), .PROG(PROG_MAIN)) i_insn_sequencer (
        .clk(clk), .rst(rst), .carry_i(carry),
        .reg_addr_o(reg_addr), .load_sel_o(load_sel), .alu_sel_o(alu_sel),
        .custom_o(custom), .pc_o(pc)
    );

    insn_sequencer #(.PC_W(3), .PROG(PROG_WRAP)) i_insn_sequencer_wrap (
        .clk(clk), .rst(rst2), .carry_i(carry2),
        .reg_addr_o(reg_addr2), .load_sel_o(load_sel2), .alu_sel_o(alu_sel2),
        .custom_o(custom2), .pc_o(pc2)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R2 and R3 field checks from the stored word
    task automatic chk_fields(input logic [7:0] w, input logic [1:0] ra,
                              input logic ls, input logic as, input logic [3:0] cv);
        chk("R2 reg_addr", 8'(ra), 8'(w[5:4]));
        chk("R2 load_sel", 8'(ls), 8'(w[3]));
        chk("R2 alu_sel", 8'(as), 8'(w[2]));
        chk("R3 custom", 8'(cv), {5'b0, w[2:0]});
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 reset pc", 8'(pc), 8'd0);
        carry = 1'b1;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R1 pc held in reset", 8'(pc), 8'd0);
        rst = 1'b0;

        // vector walk: R4 steps, R5 jump, R6 both carry values, R7 J=C=1, R8
        for (int k = 0; k < 16; k++) begin
            logic [7:0] w;
            carry = VEC[k][3];
            #1;
            w = PROG_MAIN[VEC[k][2:0]*8 +: 8];
            chk($sformatf("R4/R5/R6/R7 pc row %0d", k), 8'(pc), 8'(VEC[k][2:0]));
            chk_fields(w, reg_addr, load_sel, alu_sel, custom);
            @(negedge clk);
        end
        #1;
        chk("R5 pc after last jump", 8'(pc), 8'd2);

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk); #1;
        chk("R1 mid-run reset", 8'(pc), 8'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 first step after reset", 8'(pc), 8'd1);

        // R4 wrap and R8 ignored J/C/carry on register-writing words
        @(negedge clk);
        rst2 = 1'b0;
        for (int k = 0; k < 11; k++) begin
            #1;
            chk($sformatf("R4/R8 wrap pc step %0d", k), 8'(pc2), 8'(k % 8));
            chk_fields(PROG_WRAP[(k % 8)*8 +: 8], reg_addr2, load_sel2, alu_sel2, custom2);
            carry2 = ~carry2;
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule